// File: doc/BRIEF.md
# DSI Host Link State Controller

This block sequences the bring-up of a display serial interface host link and then polices which operating modes may be requested. It holds one of four link states: INIT (not yet brought up), STOP (lanes idle in low-power signalling), HSCLK (high-speed clock running) and ULPS (ultra-low-power). An init request drives the clock lane and a configurable number of data lanes. The block then polls a lane status input until every enabled lane reports the stop condition, or until a bounded number of polls has run out.

Once the link is in STOP, a high-speed enable request turns on the high-speed clock and puts both the display-controller and the CPU transfer paths into high-speed mode. This move is refused when the clock source is external bypass. Requests to select a transfer mode, and requests to write data, are accepted or rejected according to the current link state. A rejection produces a one-cycle error pulse. The physical layer and packet formatting sit outside this block.

Top module: `dsi_link_ctrl`

## Requirements
- R1: After synchronous reset `linkState` is INIT (0). `laneEn`, `hsClkOn`, `lcdHsMode` and `cpuHsMode` are all zero, and no error or grant pulse is asserted.
- R2: The lane enable mask places the clock lane on bit 0 and data lanes 0..3 on bits 1..4. An accepted init with lane count N (1..4) drives bit 0 and bits 1..N high, with all other bits low, in the cycle after the request.
- R3: An init request in INIT with lane count 0 or greater than 4 gives an `initErr` pulse in the next cycle. The state stays INIT and `laneEn` stays zero.
- R4: State encoding is INIT=0, STOP=1, HSCLK=2, ULPS=3. While polling, the block moves to STOP on the first clock in which `laneStop` is high. During polling, requests other than write are ignored.
- R5: If `laneStop` stays low for 100 consecutive polls, `initErr` pulses for one cycle right after the 100th poll and the state stays INIT. A stop report on the 100th poll still reaches STOP without error.
- R6: An init request in any state other than INIT is ignored: there is no error, and the state and `laneEn` do not change.
- R7: An HS-enable request in STOP with `clkSrc` not equal to 2 (external bypass) moves the link to HSCLK. It also sets `hsClkOn`, `lcdHsMode` and `cpuHsMode` in the next cycle.
- R8: An HS-enable request with `clkSrc`=2, or one made in any state other than STOP, leaves the state and all mode outputs unchanged and raises no error.
- R9: A transfer-mode request with `xferVideo`=1 is accepted only in HSCLK, where it sets `lcdHsMode`. In any other state it pulses `modeErr`.
- R10: A transfer-mode request with `xferVideo`=0 pulses `modeErr` in INIT or ULPS. In STOP or HSCLK it sets `cpuHsMode`.
- R11: A ULPS request in STOP or HSCLK moves the link to ULPS and clears `hsClkOn`, `lcdHsMode` and `cpuHsMode`. A ULPS exit request in ULPS returns the link to STOP. A ULPS request in INIT is ignored.
- R12: A write request in ULPS pulses `writeErr`. In any other state it pulses `writeGrant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| laneCount | input | 3 | Number of data lanes to enable (valid 1..4) |
| clkSrc | input | 2 | Byte clock source; 2 = external bypass |
| initReq | input | 1 | Start link bring-up |
| hsEnReq | input | 1 | Request high-speed clocking |
| ulpsReq | input | 1 | Enter ultra-low-power state |
| ulpsExitReq | input | 1 | Leave ultra-low-power state |
| xferReq | input | 1 | Transfer-mode select request |
| xferVideo | input | 1 | 1 = video path high-speed, 0 = CPU path |
| writeReq | input | 1 | Data write request |
| laneStop | input | 1 | All enabled lanes report the stop condition |
| laneEn | output | 5 | Lane enables: bit 0 clock, bits 1..4 data lanes |
| hsClkOn | output | 1 | High-speed clock running |
| lcdHsMode | output | 1 | Display-controller path in high-speed mode |
| cpuHsMode | output | 1 | CPU path in high-speed mode |
| linkState | output | 2 | Current link state |
| initErr | output | 1 | Bring-up error pulse |
| modeErr | output | 1 | Rejected transfer-mode request pulse |
| writeErr | output | 1 | Rejected write pulse |
| writeGrant | output | 1 | Accepted write pulse |

## Verification
The assertions assume that at most one of the state-changing requests is high in any cycle. They also assume that `laneCount` and `clkSrc` are held steady around a request, so that any state the block holds can be traced to a single request. The bench keeps to this by raising each request for exactly one clock, with inputs driven between edges. Before any mode request, it resets the block and walks it to the target state through requests already checked. Lane count and clock source are swept over every encoding, and every transfer and write request is tried in each of the four states.

// File: rtl/dsi_link_pkg.sv
package dsi_link_pkg;

  typedef enum logic [1:0] {
    LS_INIT  = 2'd0,
    LS_STOP  = 2'd1,
    LS_HSCLK = 2'd2,
    LS_ULPS  = 2'd3
  } linkState_e;

  localparam logic [1:0] CLK_SRC_BYPASS = 2'd2;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadLanes;
    logic startPoll;
    logic pollStep;
    logic setAllHs;
    logic setVideoHs;
    logic setCpuHs;
    logic clrHs;
  } dpCtrl_t;

endpackage

// File: rtl/dsi_link_dp.sv
module dsi_link_dp
  import dsi_link_pkg::*;
#(
  parameter int NUM_DATA_LANES = 4,
  parameter int POLL_LIMIT     = 100,
  localparam int CNT_W = $clog2(POLL_LIMIT + 1),
  localparam int LC_W  = $clog2(NUM_DATA_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpCtrl_t                 ctrl,
  input  logic [LC_W-1:0]         laneCount,
  output logic [NUM_DATA_LANES:0] laneEn,
  output logic                    hsClkOn,
  output logic                    lcdHsMode,
  output logic                    cpuHsMode,
  output logic                    pollLast
);

  logic [NUM_DATA_LANES-1:0] dataMask;
  logic [CNT_W-1:0]          pollCnt;

  // contiguous data-lane mask: lane i is on when the count exceeds i
  for (genvar i = 0; i < NUM_DATA_LANES; i++) begin : g_mask
    assign dataMask[i] = (int'(laneCount) > i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      laneEn <= '0;
    end else if (ctrl.loadLanes) begin
      laneEn <= {dataMask, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pollCnt <= '0;
    end else if (ctrl.startPoll) begin
      pollCnt <= CNT_W'(POLL_LIMIT);
    end else if (ctrl.pollStep) begin
      pollCnt <= pollCnt - 1'b1;
    end
  end

  assign pollLast = (pollCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hsClkOn   <= 1'b0;
      lcdHsMode <= 1'b0;
      cpuHsMode <= 1'b0;
    end else if (ctrl.clrHs) begin
      hsClkOn   <= 1'b0;
      lcdHsMode <= 1'b0;
      cpuHsMode <= 1'b0;
    end else begin
      if (ctrl.setAllHs) begin
        hsClkOn   <= 1'b1;
        lcdHsMode <= 1'b1;
        cpuHsMode <= 1'b1;
      end
      if (ctrl.setVideoHs) lcdHsMode <= 1'b1;
      if (ctrl.setCpuHs)   cpuHsMode <= 1'b1;
    end
  end

  logic [NUM_DATA_LANES:0] dataPlusOne;
  assign dataPlusOne = {1'b0, laneEn[NUM_DATA_LANES:1]} + 1'b1;

  // R2
  data_contig_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(dataPlusOne));

  // R2
  clk_lane_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    (laneEn[NUM_DATA_LANES:1] != '0) |-> laneEn[0]);

  // R5
  poll_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.pollStep |-> (pollCnt > CNT_W'(1)));

endmodule

// File: rtl/dsi_link_fsm.sv
module dsi_link_fsm
  import dsi_link_pkg::*;
#(
  parameter int NUM_DATA_LANES = 4,
  localparam int LC_W = $clog2(NUM_DATA_LANES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LC_W-1:0] laneCount,
  input  logic [1:0]      clkSrc,
  input  logic            initReq,
  input  logic            hsEnReq,
  input  logic            ulpsReq,
  input  logic            ulpsExitReq,
  input  logic            xferReq,
  input  logic            xferVideo,
  input  logic            writeReq,
  input  logic            laneStop,
  input  logic            pollLast,
  output dpCtrl_t         ctrl,
  output linkState_e      state,
  output logic            initErr,
  output logic            modeErr,
  output logic            writeErr,
  output logic            writeGrant
);

  linkState_e nState;
  logic polling, nPolling;
  logic initErrN, modeErrN;
  logic countOk;

  assign countOk = (laneCount != '0) && (int'(laneCount) <= NUM_DATA_LANES);

  always_comb begin
    ctrl     = '0;
    nState   = state;
    nPolling = polling;
    initErrN = 1'b0;
    modeErrN = 1'b0;
    if (polling) begin
      if (laneStop) begin
        nPolling = 1'b0;
        nState   = LS_STOP;
      end else if (pollLast) begin
        nPolling = 1'b0;
        initErrN = 1'b1;
      end else begin
        ctrl.pollStep = 1'b1;
      end
    end else begin
      unique case (state)
        LS_INIT: begin
          if (initReq) begin
            if (countOk) begin
              ctrl.loadLanes = 1'b1;
              ctrl.startPoll = 1'b1;
              nPolling       = 1'b1;
            end else begin
              initErrN = 1'b1;
            end
          end else if (xferReq) begin
            modeErrN = 1'b1;
          end
        end
        LS_STOP: begin
          if (hsEnReq) begin
            if (clkSrc != CLK_SRC_BYPASS) begin
              nState        = LS_HSCLK;
              ctrl.setAllHs = 1'b1;
            end
          end else if (ulpsReq) begin
            nState     = LS_ULPS;
            ctrl.clrHs = 1'b1;
          end else if (xferReq) begin
            if (xferVideo) modeErrN = 1'b1;
            else           ctrl.setCpuHs = 1'b1;
          end
        end
        LS_HSCLK: begin
          if (ulpsReq) begin
            nState     = LS_ULPS;
            ctrl.clrHs = 1'b1;
          end else if (xferReq) begin
            if (xferVideo) ctrl.setVideoHs = 1'b1;
            else           ctrl.setCpuHs   = 1'b1;
          end
        end
        LS_ULPS: begin
          if (ulpsExitReq) begin
            nState = LS_STOP;
          end else if (xferReq) begin
            modeErrN = 1'b1;
          end
        end
        default: nState = LS_INIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LS_INIT;
      polling    <= 1'b0;
      initErr    <= 1'b0;
      modeErr    <= 1'b0;
      writeErr   <= 1'b0;
      writeGrant <= 1'b0;
    end else begin
      state      <= nState;
      polling    <= nPolling;
      initErr    <= initErrN;
      modeErr    <= modeErrN;
      writeErr   <= writeReq && (state == LS_ULPS);
      writeGrant <= writeReq && (state != LS_ULPS);
    end
  end

  // R8
  bypass_blocks_hs_chk: assert property (@(posedge clk) disable iff (rst)
    (state == LS_STOP && hsEnReq && clkSrc == CLK_SRC_BYPASS) |=> (state == LS_STOP));

  // R12
  write_err_only_ulps_chk: assert property (@(posedge clk) disable iff (rst)
    writeErr |-> ($past(state) == LS_ULPS));

  // R12
  write_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(writeErr && writeGrant));

  // R4
  stop_from_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (polling && laneStop) |=> (state == LS_STOP && !initErr));

endmodule

// File: rtl/dsi_link_ctrl.sv
module dsi_link_ctrl
  import dsi_link_pkg::*;
#(
  parameter int NUM_DATA_LANES = 4,
  parameter int POLL_LIMIT     = 100,
  localparam int LC_W = $clog2(NUM_DATA_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LC_W-1:0]         laneCount,
  input  logic [1:0]              clkSrc,
  input  logic                    initReq,
  input  logic                    hsEnReq,
  input  logic                    ulpsReq,
  input  logic                    ulpsExitReq,
  input  logic                    xferReq,
  input  logic                    xferVideo,
  input  logic                    writeReq,
  input  logic                    laneStop,
  output logic [NUM_DATA_LANES:0] laneEn,
  output logic                    hsClkOn,
  output logic                    lcdHsMode,
  output logic                    cpuHsMode,
  output logic [1:0]              linkState,
  output logic                    initErr,
  output logic                    modeErr,
  output logic                    writeErr,
  output logic                    writeGrant
);

  dpCtrl_t    ctrl;
  linkState_e state;
  logic       pollLast;

  dsi_link_fsm #(.NUM_DATA_LANES(NUM_DATA_LANES)) u_fsm (
    .clk(clk), .rst(rst), .laneCount(laneCount), .clkSrc(clkSrc),
    .initReq(initReq), .hsEnReq(hsEnReq), .ulpsReq(ulpsReq),
    .ulpsExitReq(ulpsExitReq), .xferReq(xferReq), .xferVideo(xferVideo),
    .writeReq(writeReq), .laneStop(laneStop), .pollLast(pollLast),
    .ctrl(ctrl), .state(state), .initErr(initErr), .modeErr(modeErr),
    .writeErr(writeErr), .writeGrant(writeGrant)
  );

  dsi_link_dp #(.NUM_DATA_LANES(NUM_DATA_LANES), .POLL_LIMIT(POLL_LIMIT)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .laneCount(laneCount),
    .laneEn(laneEn), .hsClkOn(hsClkOn), .lcdHsMode(lcdHsMode),
    .cpuHsMode(cpuHsMode), .pollLast(pollLast)
  );

  assign linkState = state;

  // R7
  hs_clk_state_chk: assert property (@(posedge clk) disable iff (rst)
    hsClkOn |-> (state == LS_HSCLK));

  // R9
  video_hs_state_chk: assert property (@(posedge clk) disable iff (rst)
    lcdHsMode |-> (state == LS_HSCLK));

  // R11
  ulps_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == LS_ULPS) |-> !(hsClkOn || cpuHsMode));

  // R4
  stop_has_clk_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (state != LS_INIT) |-> laneEn[0]);

endmodule

// File: tb/dsi_link_ctrl_bench.sv
`timescale 1ns/1ps
module dsi_link_ctrl_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] laneCount = 3'd1;
  logic [1:0] clkSrc = 2'd0;
  logic initReq = 0, hsEnReq = 0, ulpsReq = 0, ulpsExitReq = 0;
  logic xferReq = 0, xferVideo = 0, writeReq = 0, laneStop = 0;
  logic [4:0] laneEn;
  logic hsClkOn, lcdHsMode, cpuHsMode;
  logic [1:0] linkState;
  logic initErr, modeErr, writeErr, writeGrant;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  dsi_link_ctrl u_dsi_link_ctrl (
    .clk(clk), .rst(rst), .laneCount(laneCount), .clkSrc(clkSrc),
    .initReq(initReq), .hsEnReq(hsEnReq), .ulpsReq(ulpsReq),
    .ulpsExitReq(ulpsExitReq), .xferReq(xferReq), .xferVideo(xferVideo),
    .writeReq(writeReq), .laneStop(laneStop), .laneEn(laneEn),
    .hsClkOn(hsClkOn), .lcdHsMode(lcdHsMode), .cpuHsMode(cpuHsMode),
    .linkState(linkState), .initErr(initErr), .modeErr(modeErr),
    .writeErr(writeErr), .writeGrant(writeGrant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
    cyc();
  endtask

  // reset then bring the link to STOP with n data lanes
  task automatic bringUp(input int n);
    doReset();
    clkSrc = 2'd0;
    laneCount = 3'(n);
    laneStop = 1'b1;
    initReq = 1'b1; cyc(); initReq = 1'b0;
    cyc();
  endtask

  // reach state st: 0 INIT, 1 STOP, 2 HSCLK, 3 ULPS
  task automatic reach(input int st);
    if (st == 0) doReset();
    else begin
      bringUp(2);
      if (st == 2) begin hsEnReq = 1'b1; cyc(); hsEnReq = 1'b0; end
      if (st == 3) begin ulpsReq = 1'b1; cyc(); ulpsReq = 1'b0; end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int polls;
    doReset();
    // R1
    chk("R1 state", linkState, 0);
    chk("R1 laneEn", laneEn, 0);
    chk("R1 hs", {hsClkOn, lcdHsMode, cpuHsMode}, 0);
    chk("R1 pulses", {initErr, modeErr, writeErr, writeGrant}, 0);

    // R2 / R3: sweep every lane count
    for (int n = 0; n < 8; n++) begin
      bit ok;
      ok = (n >= 1 && n <= 4);
      doReset();
      laneCount = 3'(n); laneStop = 1'b1;
      initReq = 1'b1; cyc(); initReq = 1'b0;
      chk(ok ? "R2 laneEn" : "R3 laneEn", laneEn, ok ? ((((1 << n) - 1) << 1) | 1) : 0);
      chk("R3 initErr", initErr, ok ? 0 : 1);
      cyc();
      chk("R4 state after poll", linkState, ok ? 1 : 0);
      chk("R3 pulse ends", initErr, 0);
    end

    // R5 timeout count
    doReset();
    laneCount = 3'd2; laneStop = 1'b0;
    initReq = 1'b1; cyc(); initReq = 1'b0;
    polls = 0;
    while (!initErr && polls < 300) begin cyc(); polls++; end
    chk("R5 polls to timeout", polls, 100);
    chk("R5 state", linkState, 0);
    cyc();
    chk("R5 one-cycle pulse", initErr, 0);

    // R5 stop on the last poll
    doReset();
    laneCount = 3'd1; laneStop = 1'b0;
    initReq = 1'b1; cyc(); initReq = 1'b0;
    repeat (99) cyc();
    chk("R5 still polling", linkState, 0);
    chk("R5 no early err", initErr, 0);
    laneStop = 1'b1; cyc();
    chk("R5 last poll stop", linkState, 1);
    chk("R5 last poll no err", initErr, 0);

    // R4 requests ignored while polling
    doReset();
    laneCount = 3'd1; laneStop = 1'b0;
    initReq = 1'b1; cyc(); initReq = 1'b0;
    xferReq = 1'b1; xferVideo = 1'b0; cyc(); xferReq = 1'b0;
    chk("R4 xfer ignored polling", modeErr, 0);

    // R6 init outside INIT
    bringUp(3);
    laneCount = 3'd1;
    initReq = 1'b1; cyc(); initReq = 1'b0;
    chk("R6 no err", initErr, 0);
    chk("R6 state", linkState, 1);
    chk("R6 lanes", laneEn, 5'b01111);

    // R7 / R8 sweep clock sources
    for (int s = 0; s < 4; s++) begin
      bit go;
      go = (s != 2);
      bringUp(4);
      clkSrc = 2'(s);
      hsEnReq = 1'b1; cyc(); hsEnReq = 1'b0;
      chk(go ? "R7 state" : "R8 state", linkState, go ? 2 : 1);
      chk(go ? "R7 hs outs" : "R8 hs outs", {hsClkOn, lcdHsMode, cpuHsMode}, go ? 7 : 0);
      chk("R8 no err", {initErr, modeErr}, 0);
    end
    doReset();
    hsEnReq = 1'b1; cyc(); hsEnReq = 1'b0;
    chk("R8 hs in INIT", {linkState, hsClkOn}, 0);

    // R9 / R10 in each state
    for (int st = 0; st < 4; st++) begin
      for (int v = 0; v < 2; v++) begin
        bit rej;
        rej = v ? (st != 2) : (st == 0 || st == 3);
        reach(st);
        xferVideo = v[0]; xferReq = 1'b1; cyc(); xferReq = 1'b0;
        chk(v ? "R9 modeErr" : "R10 modeErr", modeErr, rej ? 1 : 0);
        chk(v ? "R9 lcdHsMode" : "R10 lcdHsMode", lcdHsMode, (st == 2) ? 1 : 0);
        chk(v ? "R9 cpuHsMode" : "R10 cpuHsMode", cpuHsMode,
            (st == 2 || (st == 1 && v == 0)) ? 1 : 0);
        chk("R9 state kept", linkState, st);
      end
    end

    // R11 ULPS
    reach(2);
    ulpsReq = 1'b1; cyc(); ulpsReq = 1'b0;
    chk("R11 enter ulps", linkState, 3);
    chk("R11 hs cleared", {hsClkOn, lcdHsMode, cpuHsMode}, 0);
    ulpsExitReq = 1'b1; cyc(); ulpsExitReq = 1'b0;
    chk("R11 exit to stop", linkState, 1);
    doReset();
    ulpsReq = 1'b1; cyc(); ulpsReq = 1'b0;
    chk("R11 ignored in INIT", linkState, 0);

    // R12 writes in each state
    for (int st = 0; st < 4; st++) begin
      reach(st);
      writeReq = 1'b1; cyc(); writeReq = 1'b0;
      chk("R12 writeErr", writeErr, (st == 3) ? 1 : 0);
      chk("R12 writeGrant", writeGrant, (st == 3) ? 0 : 1);
      cyc();
      chk("R12 pulse ends", {writeErr, writeGrant}, 0);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule